// File: doc/BRIEF.md
# Two-Port Shared Memory with Address-Contention Arbiter

This block is a synchronous memory with two independent access ports, called A (left) and B (right). Each port has its own enable, output enable, write strobe, address and write data, and returns read data one clock after the request. Accesses to different addresses proceed in parallel in the same cycle. When both ports are enabled at the same address in the same cycle, an on-block arbiter picks one winner. The loser's write is dropped and a registered busy flag is raised to the loser one cycle later, in step with the read data.

A strap input sets how the busy flags are used. With the strap high, the block is the master. It drives its busy outputs from its own arbiter and commits writes at once. With the strap low, the block is a slave that obeys busy inputs supplied by a master. The slave's busy outputs stay low. A slave delays each write by one cycle and commits it only if its busy input for that port is low in that later cycle. Several instances can therefore be placed side by side to build a wider word, with every instance following one arbitration result.

Top module: `dpra_arb`

## Requirements
- R1: Accesses from the two ports to different addresses both take effect in the same cycle. Neither port is flagged busy.
- R2: In master mode a port's busy output is high one cycle after a cycle in which both ports were enabled at the same address. In that case exactly one of the two busy outputs is high. After any other cycle both busy outputs are low.
- R3: In a clash where neither port was enabled at the clashing address in the previous cycle, port A wins and port B is flagged busy.
- R4: In a clash where only one port was enabled at that address in the previous cycle, that port wins. If both were (a clash on that address in the previous cycle), the previous winner wins again.
- R5: In master mode a write happens when the port is enabled with its strobe high and has not lost arbitration. A losing port's write leaves the memory unchanged.
- R6: A losing read returns the value stored before the clash cycle. A read of that address in the next cycle returns the winner's new data.
- R7: Read data appears one cycle after a cycle with enable high, output enable high and write strobe low. After any other cycle the read data is all zeros.
- R8: A write strobe with the port's enable low changes nothing.
- R9: In slave mode both busy outputs stay low. A write issued in cycle t is stored at the end of cycle t+1 only if that port's busy input is low in cycle t+1. Otherwise the write is dropped.
- R10: During and straight after reset, both busy outputs and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | Strap: 1 = master (own arbiter drives busy), 0 = slave (busy inputs obeyed) |
| a_en | input | 1 | Port A enable |
| a_oe | input | 1 | Port A output enable |
| a_we | input | 1 | Port A write strobe, 1 = write |
| a_addr | input | AW | Port A address, AW = clog2(DEPTH) |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, one cycle latency |
| a_busy_o | output | 1 | Port A lost arbitration (master mode) |
| a_busy_i | input | 1 | Port A busy from master (slave mode) |
| b_en | input | 1 | Port B enable |
| b_oe | input | 1 | Port B output enable |
| b_we | input | 1 | Port B write strobe, 1 = write |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, one cycle latency |
| b_busy_o | output | 1 | Port B lost arbitration (master mode) |
| b_busy_i | input | 1 | Port B busy from master (slave mode) |

## Verification
A wrong arbiter history, such as a stale record of which port held an address or of who lost last, shows up on the busy outputs one cycle after the next clash. It shows up as the wrong port flagged, or as both or neither flagged. A suppression error stays hidden until the location is read back. A dropped winner write or a leaked loser write then appears on the read bus one cycle after that read. In slave mode a wrong pending-write register shows up only on a read at least two cycles after the write.

// File: rtl/dpra_pkg.sv
package dpra_pkg;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dpra_arbiter.sv
module dpra_arbiter
   import dpra_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_en,
   input  logic [AW-1:0] a_addr,
   input  logic          b_en,
   input  logic [AW-1:0] b_addr,
   output logic          lose_a,
   output logic          lose_b,
   output logic          busy_a_q,
   output logic          busy_b_q
);

   logic          prev_a_en, prev_b_en;
   logic [AW-1:0] prev_a_addr, prev_b_addr;
   logic          clash, held_a, held_b;
   side_e         winner;

   always_comb begin
      clash  = a_en && b_en && (a_addr == b_addr);
      held_a = prev_a_en && (prev_a_addr == a_addr);
      held_b = prev_b_en && (prev_b_addr == b_addr);
      if (held_b && (!held_a || busy_a_q)) winner = SIDE_B;
      else                                 winner = SIDE_A;
      lose_a = clash && (winner == SIDE_B);
      lose_b = clash && (winner == SIDE_A);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_a_en   <= 1'b0;
         prev_b_en   <= 1'b0;
         prev_a_addr <= '0;
         prev_b_addr <= '0;
         busy_a_q    <= 1'b0;
         busy_b_q    <= 1'b0;
      end else begin
         prev_a_en   <= a_en;
         prev_b_en   <= b_en;
         prev_a_addr <= a_addr;
         prev_b_addr <= b_addr;
         busy_a_q    <= lose_a;
         busy_b_q    <= lose_b;
      end
   end

endmodule

// File: rtl/dpra_wr_stage.sv
module dpra_wr_stage #(
   parameter int AW = 12,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          lose,
   input  logic          busy_in,
   output logic          commit,
   output logic [AW-1:0] c_addr,
   output logic [DW-1:0] c_data
);

   logic          pend_we;
   logic [AW-1:0] pend_addr;
   logic [DW-1:0] pend_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_we   <= 1'b0;
         pend_addr <= '0;
         pend_data <= '0;
      end else begin
         pend_we   <= en && we;
         pend_addr <= addr;
         pend_data <= wdata;
      end
   end

   always_comb begin
      if (master) begin
         commit = en && we && !lose;
         c_addr = addr;
         c_data = wdata;
      end else begin
         commit = pend_we && !busy_in;
         c_addr = pend_addr;
         c_data = pend_data;
      end
   end

endmodule

// File: rtl/dpra_mem.sv
module dpra_mem #(
   parameter int DEPTH = 4096,
   parameter int DW    = 16,
   parameter int AW    = 12,
   parameter int NP    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NP-1:0]          wr_en,
   input  logic [NP-1:0][AW-1:0]  wr_addr,
   input  logic [NP-1:0][DW-1:0]  wr_data,
   input  logic [NP-1:0]          rd_en,
   input  logic [NP-1:0][AW-1:0]  rd_addr,
   output logic [NP-1:0][DW-1:0]  rd_data
);

   logic [DW-1:0] cells [DEPTH];

   // later ports land last when two commits share an address
   always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++) begin
         if (wr_en[p]) cells[wr_addr[p]] <= wr_data[p];
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_rd
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= '0;
         else if (rd_en[p]) q <= cells[rd_addr[p]];
         else               q <= '0;
      end
      assign rd_data[p] = q;
   end

endmodule

// File: rtl/dpra_arb.sv
module dpra_arb
   import dpra_pkg::*;
#(
   parameter  int DEPTH = 4096,
   parameter  int DW    = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master_mode,
   input  logic          a_en,
   input  logic          a_oe,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   output logic          a_busy_o,
   input  logic          a_busy_i,
   input  logic          b_en,
   input  logic          b_oe,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata,
   output logic          b_busy_o,
   input  logic          b_busy_i
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dpra_arb: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("dpra_arb: DW must be at least 1");
   end

   logic lose_a, lose_b, busy_a_q, busy_b_q;
   logic cm_a, cm_b;
   logic [AW-1:0] ca_a, ca_b;
   logic [DW-1:0] cd_a, cd_b;
   logic [NUM_SIDES-1:0][DW-1:0] rd_bus;

   dpra_arbiter #(.AW(AW)) u_arbiter (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_en     (a_en),
      .a_addr   (a_addr),
      .b_en     (b_en),
      .b_addr   (b_addr),
      .lose_a   (lose_a),
      .lose_b   (lose_b),
      .busy_a_q (busy_a_q),
      .busy_b_q (busy_b_q)
   );

   dpra_wr_stage #(.AW(AW), .DW(DW)) u_wr_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .master  (master_mode),
      .en      (a_en),
      .we      (a_we),
      .addr    (a_addr),
      .wdata   (a_wdata),
      .lose    (lose_a),
      .busy_in (a_busy_i),
      .commit  (cm_a),
      .c_addr  (ca_a),
      .c_data  (cd_a)
   );

   dpra_wr_stage #(.AW(AW), .DW(DW)) u_wr_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .master  (master_mode),
      .en      (b_en),
      .we      (b_we),
      .addr    (b_addr),
      .wdata   (b_wdata),
      .lose    (lose_b),
      .busy_in (b_busy_i),
      .commit  (cm_b),
      .c_addr  (ca_b),
      .c_data  (cd_b)
   );

   dpra_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .NP(NUM_SIDES)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   ({cm_b, cm_a}),
      .wr_addr ({ca_b, ca_a}),
      .wr_data ({cd_b, cd_a}),
      .rd_en   ({b_en && b_oe && !b_we, a_en && a_oe && !a_we}),
      .rd_addr ({b_addr, a_addr}),
      .rd_data (rd_bus)
   );

   assign a_rdata  = rd_bus[SIDE_A];
   assign b_rdata  = rd_bus[SIDE_B];
   assign a_busy_o = master_mode && busy_a_q;
   assign b_busy_o = master_mode && busy_b_q;

endmodule

// File: rtl/dpra_arb_chk.sv
module dpra_arb_chk #(
   parameter int AW = 12,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          master_mode,
   input logic          a_en,
   input logic          a_oe,
   input logic          a_we,
   input logic [AW-1:0] a_addr,
   input logic [DW-1:0] a_rdata,
   input logic          a_busy_o,
   input logic          b_en,
   input logic          b_oe,
   input logic          b_we,
   input logic [AW-1:0] b_addr,
   input logic [DW-1:0] b_rdata,
   input logic          b_busy_o
);

   AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && $past(master_mode) && $past(a_en && b_en && (a_addr == b_addr)))
      |-> (a_busy_o != b_busy_o)); // R2

   AST_NO_SPURIOUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(a_en && b_en && (a_addr == b_addr))) |-> (!a_busy_o && !b_busy_o)); // R2

   AST_SLAVE_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (!a_busy_o && !b_busy_o)); // R9

   AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(a_en && a_oe && !a_we)) |-> (a_rdata == '0)); // R7

   AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(b_en && b_oe && !b_we)) |-> (b_rdata == '0)); // R7

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!a_busy_o && !b_busy_o); // R10
      end
   end

endmodule

bind dpra_arb dpra_arb_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_mode (master_mode),
   .a_en        (a_en),
   .a_oe        (a_oe),
   .a_we        (a_we),
   .a_addr      (a_addr),
   .a_rdata     (a_rdata),
   .a_busy_o    (a_busy_o),
   .b_en        (b_en),
   .b_oe        (b_oe),
   .b_we        (b_we),
   .b_addr      (b_addr),
   .b_rdata     (b_rdata),
   .b_busy_o    (b_busy_o)
);

// File: tb/dpra_arb_bench.sv
`timescale 1ns/1ps
module dpra_arb_bench;

   localparam int DEPTH = 4096;
   localparam int DW    = 16;
   localparam int AW    = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_mode = 1'b1;
   logic          a_en = 0, a_oe = 0, a_we = 0, a_busy_i = 0;
   logic          b_en = 0, b_oe = 0, b_we = 0, b_busy_i = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic          a_busy_o, b_busy_o;

   always #10 clk = ~clk;

   dpra_arb #(.DEPTH(DEPTH), .DW(DW)) u_dpra_arb (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .a_en(a_en), .a_oe(a_oe), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_busy_o(a_busy_o), .a_busy_i(a_busy_i),
      .b_en(b_en), .b_oe(b_oe), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_busy_o(b_busy_o), .b_busy_i(b_busy_i)
   );

   typedef struct {
      bit            chk_ar;
      bit            chk_br;
      logic [DW-1:0] ar;
      logic [DW-1:0] br;
      bit            abusy;
      bit            bbusy;
      string         tag;
   } exp_t;

   exp_t          q[$];
   logic [DW-1:0] shadow [int];
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done = 0;
   bit            pa_v = 0, pb_v = 0;
   logic [AW-1:0] pa_addr, pb_addr;
   logic [DW-1:0] pa_data, pb_data;

   task automatic compare(input string tag, input string what,
                          input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: one expected item per driven cycle, sampled 5 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.chk_ar) compare(e.tag, "a_rdata", a_rdata, e.ar);
            if (e.chk_br) compare(e.tag, "b_rdata", b_rdata, e.br);
            compare(e.tag, "a_busy_o", {15'd0, a_busy_o}, {15'd0, e.abusy});
            compare(e.tag, "b_busy_o", {15'd0, b_busy_o}, {15'd0, e.bbusy});
         end
      end
   end

   // driver: xa/xb = expected loser flags, abi/bbi = busy inputs (slave mode)
   task automatic drive(
      input bit ae, input bit aoe, input bit awe, input int aad, input int awd,
      input bit be, input bit boe, input bit bwe, input int bad, input int bwd,
      input bit xa, input bit xb, input bit abi, input bit bbi, input string tag);
      exp_t e;
      bit   rda, rdb;
      @(negedge clk);
      a_en = ae; a_oe = aoe; a_we = awe; a_addr = aad[AW-1:0]; a_wdata = awd[DW-1:0];
      b_en = be; b_oe = boe; b_we = bwe; b_addr = bad[AW-1:0]; b_wdata = bwd[DW-1:0];
      a_busy_i = abi; b_busy_i = bbi;
      rda = ae && aoe && !awe;
      rdb = be && boe && !bwe;
      e.tag    = tag;
      e.chk_ar = !rda || shadow.exists(aad);
      e.chk_br = !rdb || shadow.exists(bad);
      e.ar     = (rda && shadow.exists(aad)) ? shadow[aad] : '0;
      e.br     = (rdb && shadow.exists(bad)) ? shadow[bad] : '0;
      e.abusy  = master_mode && xa;
      e.bbusy  = master_mode && xb;
      if (master_mode) begin
         if (ae && awe && !xa) shadow[aad] = awd[DW-1:0];
         if (be && bwe && !xb) shadow[bad] = bwd[DW-1:0];
      end else begin
         if (pa_v && !abi) shadow[int'(pa_addr)] = pa_data;
         if (pb_v && !bbi) shadow[int'(pb_addr)] = pb_data;
         pa_v = ae && awe; pa_addr = aad[AW-1:0]; pa_data = awd[DW-1:0];
         pb_v = be && bwe; pb_addr = bad[AW-1:0]; pb_data = bwd[DW-1:0];
      end
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(0,0,0,0,0, 0,0,0,0,0, 0,0, 0,0, tag);
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 1'b0; master_mode = mode;
      a_en = 0; b_en = 0; a_we = 0; b_we = 0; a_oe = 0; b_oe = 0;
      a_busy_i = 0; b_busy_i = 0;
      pa_v = 0; pb_v = 0;
      repeat (2) @(negedge clk);
      // R10: reset state at the ports
      compare("R10", "a_rdata", a_rdata, '0);
      compare("R10", "b_rdata", b_rdata, '0);
      compare("R10", "busy", {14'd0, a_busy_o, b_busy_o}, '0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset(1'b1);
      idle("R10 first cycle");

      // R1: parallel writes then crossed reads, no busy
      drive(1,0,1,'h010,'h1111, 1,0,1,'h020,'h2222, 0,0, 0,0, "R1 dual write");
      drive(1,1,0,'h020,0,      1,1,0,'h010,0,      0,0, 0,0, "R1 dual read");

      // R7: no data without enable+oe, none on a write
      drive(1,0,0,'h010,0,      0,1,0,'h020,0,      0,0, 0,0, "R7 oe/en low");
      drive(1,1,1,'h050,'h5050, 0,0,0,0,0,          0,0, 0,0, "R7 write returns zero");

      // R8: strobe without enable
      drive(0,0,1,'h010,'hDEAD, 0,0,0,0,0,          0,0, 0,0, "R8 strobe no enable");
      drive(1,1,0,'h010,0,      0,0,0,0,0,          0,0, 0,0, "R8 readback");

      // R3 fresh tie, then R4 previous winner keeps
      idle("gap");
      drive(1,0,1,'h030,'hAAAA, 1,0,1,'h030,'hBBBB, 0,1, 0,0, "R3 fresh tie left wins");
      drive(1,0,1,'h030,'hCCCC, 1,0,1,'h030,'hDDDD, 0,1, 0,0, "R4 repeat clash winner keeps");
      drive(0,0,0,0,0,          1,1,0,'h030,0,      0,0, 0,0, "R5 winner data stored");

      // R4 holder wins, R5 loser write dropped
      idle("gap");
      drive(0,0,0,0,0,          1,0,1,'h040,'h4444, 0,0, 0,0, "R4 b takes address");
      drive(1,0,1,'h040,'h5555, 1,1,0,'h040,0,      1,0, 0,0, "R4 holder b wins");
      drive(1,0,1,'h040,'h6666, 1,1,0,'h040,0,      1,0, 0,0, "R4 both held, b keeps");
      drive(1,1,0,'h040,0,      0,0,0,0,0,          0,0, 0,0, "R5 loser write dropped");

      // R6 losing read sees old data, next cycle sees new
      idle("gap");
      drive(0,0,0,0,0,          1,1,0,'h010,0,      0,0, 0,0, "R6 b holds");
      drive(1,1,0,'h010,0,      1,0,1,'h010,'hABCD, 1,0, 0,0, "R6 losing read old");
      drive(1,1,0,'h010,0,      0,0,0,0,0,          0,0, 0,0, "R6 flow-through new");

      idle("drain");
      idle("drain");

      // R9 slave mode
      do_reset(1'b0);
      drive(1,0,1,'h100,'h1234, 0,0,0,0,0,          0,0, 0,0, "R9 slave write");
      drive(0,0,0,0,0,          0,0,0,0,0,          0,0, 0,0, "R9 commit cycle");
      drive(1,1,0,'h100,0,      0,0,0,0,0,          0,0, 0,0, "R9 committed");
      drive(1,0,1,'h100,'h9999, 0,0,0,0,0,          0,0, 0,0, "R9 slave write 2");
      drive(0,0,0,0,0,          0,0,0,0,0,          0,0, 1,0, "R9 busy in drops");
      drive(1,1,0,'h100,0,      0,0,0,0,0,          0,0, 0,0, "R9 write dropped");
      drive(1,0,1,'h110,'h0F0F, 1,0,1,'h110,'hF0F0, 0,0, 0,0, "R9 clash no busy out");
      drive(0,0,0,0,0,          0,0,0,0,0,          0,0, 0,1, "R9 b dropped a kept");
      drive(1,1,0,'h110,0,      1,1,0,'h110,0,      0,0, 0,0, "R9 readback");
      idle("drain");
      idle("drain");
      @(negedge clk);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule